// File: doc/BRIEF.md
# Serial Channel Trim Store

This block keeps one small level-correction code per readout channel. The codes drive a per-channel trim converter elsewhere in the chip. Coefficients come in on a single serial data line that has its own shift clock. The bits are gathered into a six-bit shift register. A rising edge on a load strobe then copies the gathered word into the entry of whichever channel the readout sequencer is addressing at that moment.

Because the write address comes from the running readout, the codes can be set once after power-up or changed while frames are being read. An external controller times each strobe to fall inside the readout slot of the channel it means to update.

The stored code of the channel being read is presented on a registered output. A second registered port reads any entry for debug. Code 0 selects the low end of the trim range and code 63 selects the high end.

Top module: `chan_trim_store`

## Requirements
- R1: On every rising edge of `ser_clk`, the assembly register shifts left and takes the bit on `ser_data` as its new least-significant bit. The register therefore holds the last six bits received, with the earliest of them as bit 5. Toggling `ser_clk` alone never changes any stored entry.
- R2: A low-to-high transition of `load_en` writes the assembled word into the entry addressed by `rd_chan` at the moment the strobe is seen. One rising edge performs exactly one write. Shifting more bits while `load_en` stays high, or lowering `load_en`, writes nothing.
- R3: A `load_en` rising edge that is seen while `rd_valid` is low is ignored, and no entry changes.
- R4: Reset (synchronous, active high) returns all entries to code 0 and drives both outputs to 0 on the cycle after reset is released. This holds for a reset at start-up and for one in mid-operation.
- R5: `trim_code` equals the stored code of `rd_chan` two clock cycles after `rd_chan` is presented with `rd_valid` high. It is 0 two cycles after `rd_valid` is low.
- R6: `dbg_code` equals the stored code of entry `dbg_chan` two clock cycles after `dbg_chan` is presented, for any of the 32 entries.
- R7: The 32 entries are independent. A write changes only the addressed entry, even when codes are loaded into every channel during free-running readout.
- R8: Every code from 0 to 63 is stored and returned unchanged, including the extremes 0 (low end of trim range) and 63 (high end).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_data | input | 1 | Serial coefficient bit, most-significant bit first, asynchronous |
| ser_clk | input | 1 | Serial shift clock, sampled on its rising edge, asynchronous |
| load_en | input | 1 | Load strobe; its rising edge writes the assembled word, asynchronous |
| rd_valid | input | 1 | High while the readout sequencer addresses a channel |
| rd_chan | input | 5 | Channel currently addressed by the readout sequencer |
| dbg_chan | input | 5 | Entry selected for debug read |
| trim_code | output | 6 | Registered code of the addressed channel, 0 when none is addressed |
| dbg_code | output | 6 | Registered code of the debug-selected entry |

## Verification
A fault in the assembly register shows up as a wrong code in the entry that the next strobe writes. It is visible on the debug port two cycles after that entry is selected. A wrong write address or a duplicated write corrupts a neighbouring entry, which is why every entry is compared against an independent model after a full load during readout. A stuck fill flag or a read pipeline out of step returns stale or zero codes on `trim_code` two cycles after the channel changes. Reset faults appear as nonzero outputs on the first cycle after reset is released.

// File: rtl/trim_pkg.sv
package trim_pkg;
  localparam int unsigned CH_DEF     = 32;
  localparam int unsigned CODE_W_DEF = 6;
  localparam int unsigned SYNC_DEF   = 2;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/rise_detect.sv
module rise_detect (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic pulse
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= lvl;
  end

  assign pulse = lvl & ~prev;
endmodule

// File: rtl/sipo_shift.sv
module sipo_shift #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         bit_in,
  output logic [W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst)       word <= '0;
    else if (tick) word <= {word[W-2:0], bit_in};
  end
endmodule

// File: rtl/trim_ram.sv
module trim_ram #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned W     = 6,
  parameter int unsigned AW    = 5,
  parameter int unsigned PORTS = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          rd_en   [PORTS],
  input  logic [AW-1:0] rd_addr [PORTS],
  output logic [W-1:0]  rd_q    [PORTS],
  output logic [DEPTH-1:0] filled
);
  // Storage without reset so it maps onto block RAM; the fill flags
  // provide the cleared view after reset.
  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     filled <= '0;
    else if (we) filled[waddr] <= 1'b1;
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic [W-1:0] data_s1;
    logic         hit_s1;

    always_ff @(posedge clk) begin
      data_s1 <= store[rd_addr[p]];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        hit_s1  <= 1'b0;
        rd_q[p] <= '0;
      end else begin
        hit_s1  <= rd_en[p] & filled[rd_addr[p]];
        rd_q[p] <= hit_s1 ? data_s1 : '0;
      end
    end
  end
endmodule

// File: rtl/chan_trim_store.sv
module chan_trim_store
  import trim_pkg::*;
#(
  parameter int unsigned NUM_CH = CH_DEF,
  parameter int unsigned CODE_W = CODE_W_DEF,
  parameter int unsigned SYNC_N = SYNC_DEF,
  localparam int unsigned AW    = idx_w(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_data,
  input  logic              ser_clk,
  input  logic              load_en,
  input  logic              rd_valid,
  input  logic [AW-1:0]     rd_chan,
  input  logic [AW-1:0]     dbg_chan,
  output logic [CODE_W-1:0] trim_code,
  output logic [CODE_W-1:0] dbg_code
);
  localparam int unsigned NPORT = 2;

  logic [1:0]        ser_s;
  logic              load_s;
  logic              shift_tick;
  logic              shift_bit;
  logic              load_rise;
  logic              wr_en;
  logic [CODE_W-1:0] shift_word;
  logic [NUM_CH-1:0] filled;
  logic              rd_en   [NPORT];
  logic [AW-1:0]     rd_addr [NPORT];
  logic [CODE_W-1:0] rd_q    [NPORT];

  // Data and shift clock share one synchronizer so they stay aligned.
  bit_sync #(.W(2), .STAGES(SYNC_N)) u_ser_sync (
    .clk(clk), .rst(rst), .d({ser_data, ser_clk}), .q(ser_s)
  );

  bit_sync #(.W(1), .STAGES(SYNC_N)) u_load_sync (
    .clk(clk), .rst(rst), .d(load_en), .q(load_s)
  );

  rise_detect u_shift_edge (
    .clk(clk), .rst(rst), .lvl(ser_s[0]), .pulse(shift_tick)
  );

  rise_detect u_load_edge (
    .clk(clk), .rst(rst), .lvl(load_s), .pulse(load_rise)
  );

  assign shift_bit = ser_s[1];

  sipo_shift #(.W(CODE_W)) u_sipo (
    .clk(clk), .rst(rst), .tick(shift_tick), .bit_in(shift_bit), .word(shift_word)
  );

  // Write address is the channel under readout at the strobe.
  assign wr_en = load_rise & rd_valid;

  assign rd_en[0]   = rd_valid;
  assign rd_addr[0] = rd_chan;
  assign rd_en[1]   = 1'b1;
  assign rd_addr[1] = dbg_chan;

  trim_ram #(.DEPTH(NUM_CH), .W(CODE_W), .AW(AW), .PORTS(NPORT)) u_ram (
    .clk(clk), .rst(rst), .we(wr_en), .waddr(rd_chan), .wdata(shift_word),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_q(rd_q), .filled(filled)
  );

  assign trim_code = rd_q[0];
  assign dbg_code  = rd_q[1];
endmodule

// File: rtl/chan_trim_store_chk.sv
module chan_trim_store_chk #(
  parameter int unsigned NUM_CH = 32,
  parameter int unsigned CODE_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_valid,
  input logic              wr_en,
  input logic              shift_tick,
  input logic              shift_bit,
  input logic [CODE_W-1:0] shift_word,
  input logic [NUM_CH-1:0] filled,
  input logic [CODE_W-1:0] trim_code,
  input logic [CODE_W-1:0] dbg_code
);
  // R1
  shift_in_chk: assert property (@(posedge clk) disable iff (rst)
    shift_tick |=> (shift_word[0] == $past(shift_bit)) &&
                   (shift_word[CODE_W-1:1] == $past(shift_word[CODE_W-2:0])));

  // R1
  shift_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_tick |=> $stable(shift_word));

  // R2
  single_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  // R3
  idle_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |=> $stable(filled));

  // R4
  reset_out_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (trim_code == '0) && (dbg_code == '0));

  // R5
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_valid, 2) |-> (trim_code == '0));
endmodule

bind chan_trim_store chan_trim_store_chk #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .rd_valid(rd_valid), .wr_en(wr_en),
  .shift_tick(shift_tick), .shift_bit(shift_bit), .shift_word(shift_word),
  .filled(filled), .trim_code(trim_code), .dbg_code(dbg_code)
);

// File: tb/chan_trim_store_tb_top.sv
module chan_trim_store_tb_top;
  localparam int NCH = 32;
  localparam int PIX = 8;

  typedef struct {
    int    addr;
    int    exp;
    string tag;
  } sb_item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_data = 1'b0;
  logic       ser_clk = 1'b0;
  logic       load_en = 1'b0;
  logic       st_valid = 1'b1;
  logic [4:0] st_chan = '0;
  logic       seq_run = 1'b0;
  logic [4:0] dbg_chan = '0;
  logic       rd_valid;
  logic [4:0] rd_chan;
  logic [5:0] trim_code;
  logic [5:0] dbg_code;

  int pcnt = 0;
  int slot = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit mon_busy = 0;
  int model [NCH];
  sb_item_t sb_q [$];

  always #5 clk = ~clk;

  assign rd_chan  = seq_run ? slot[4:0] : st_chan;
  assign rd_valid = seq_run ? (slot < NCH) : st_valid;

  chan_trim_store dut_i (
    .clk(clk), .rst(rst), .ser_data(ser_data), .ser_clk(ser_clk),
    .load_en(load_en), .rd_valid(rd_valid), .rd_chan(rd_chan),
    .dbg_chan(dbg_chan), .trim_code(trim_code), .dbg_code(dbg_code)
  );

  // Free-running readout sequencer: 32 channel slots plus 2 idle slots.
  always @(negedge clk) begin
    if (!seq_run) begin
      pcnt = 0;
      slot = 0;
    end else if (pcnt == PIX - 1) begin
      pcnt = 0;
      slot = (slot == NCH + 1) ? 0 : slot + 1;
    end else begin
      pcnt = pcnt + 1;
    end
  end

  task automatic report(input bit ok, input int got, input int exp, input string tag);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic expect_entry(input int addr, input int exp, input string tag);
    sb_item_t it;
    it.addr = addr;
    it.exp  = exp;
    it.tag  = tag;
    sb_q.push_back(it);
  endtask

  task automatic drain();
    @(negedge clk);
    wait (sb_q.size() == 0 && !mon_busy);
  endtask

  // Monitor: reads each expected entry through the debug port.
  initial begin
    sb_item_t it;
    forever begin
      wait (sb_q.size() > 0);
      mon_busy = 1;
      it = sb_q.pop_front();
      @(negedge clk);
      dbg_chan = it.addr[4:0];
      repeat (3) @(negedge clk);
      report(dbg_code == it.exp[5:0], int'(dbg_code), it.exp,
             $sformatf("%s entry %0d", it.tag, it.addr));
      mon_busy = 0;
    end
  end

  task automatic shift_bits(input logic [7:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk);
      ser_data = v[i];
      repeat (2) @(negedge clk);
      ser_clk = 1'b1;
      repeat (3) @(negedge clk);
      ser_clk = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic strobe();
    @(negedge clk);
    load_en = 1'b1;
    repeat (4) @(negedge clk);
    load_en = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_trim(input int exp, input string tag);
    repeat (3) @(negedge clk);
    report(trim_code == exp[5:0], int'(trim_code), exp, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int c = 0; c < NCH; c++) model[c] = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    report(trim_code == 0, int'(trim_code), 0, "R4 trim_code after reset");
    report(dbg_code == 0, int'(dbg_code), 0, "R4 dbg_code after reset");
    for (int c = 0; c < NCH; c++) expect_entry(c, 0, "R4 reset");
    drain();

    // Static channel 5: eight bits sent, last six (101101 = 45) kept.
    st_chan = 5'd5;
    st_valid = 1'b1;
    shift_bits(8'b11_101101, 8);
    repeat (4) @(negedge clk);
    expect_entry(5, 0, "R1 shift alone no write");
    drain();
    strobe();
    expect_entry(5, 45, "R1 R2 msb-first load");
    expect_entry(6, 0, "R7 neighbour untouched");
    drain();
    check_trim(45, "R5 trim_code of addressed channel");

    // Held strobe: one write only; later bits and the falling edge write nothing.
    shift_bits(8'd19, 6);
    @(negedge clk);
    load_en = 1'b1;
    repeat (6) @(negedge clk);
    shift_bits(8'd56, 6);
    repeat (4) @(negedge clk);
    load_en = 1'b0;
    repeat (6) @(negedge clk);
    expect_entry(5, 19, "R2 single write per rising edge");
    drain();

    // Strobe while no channel addressed.
    st_chan = 5'd7;
    st_valid = 1'b0;
    shift_bits(8'd33, 6);
    strobe();
    expect_entry(7, 0, "R3 idle strobe ignored");
    drain();
    check_trim(0, "R5 trim_code zero when idle");

    // Extreme codes.
    st_valid = 1'b1;
    st_chan = 5'd9;
    shift_bits(8'd63, 6);
    strobe();
    st_chan = 5'd5;
    shift_bits(8'd0, 6);
    strobe();
    expect_entry(9, 63, "R8 max code");
    expect_entry(5, 0, "R8 min code");
    drain();

    // Load every channel during free-running readout.
    seq_run = 1'b1;
    for (int c = 0; c < NCH; c++) begin
      model[c] = (c * 37 + 5) % 64;
      shift_bits(model[c][7:0], 6);
      do @(posedge clk); while (!(slot == c && pcnt == 1));
      @(negedge clk);
      load_en = 1'b1;
      repeat (3) @(negedge clk);
      load_en = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (2 * PIX) @(negedge clk);
    seq_run = 1'b0;
    for (int c = 0; c < NCH; c++) expect_entry(c, model[c], "R6 R7 full readout load");
    drain();

    // Addressed output follows the channel.
    st_valid = 1'b1;
    for (int c = 30; c < NCH; c++) begin
      st_chan = c[4:0];
      check_trim(model[c], $sformatf("R5 trim_code channel %0d", c));
    end
    st_chan = 5'd0;
    check_trim(model[0], "R5 trim_code channel 0");

    // Reset in mid-operation.
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    report(trim_code == 0, int'(trim_code), 0, "R4 trim_code after mid reset");
    for (int c = 0; c < NCH; c++) expect_entry(c, 0, "R4 mid reset");
    drain();

    finish_run();
  end
endmodule